// File: doc/BRIEF.md
# Dual-Register Edge Input Capture

This block snapshots a running timer count when a chosen transition appears on an external input pin. The pin is asynchronous to the block clock, so it first passes through a short synchronizer chain. Each synchronized transition is compared with a selectable edge mode.

Two capture registers take successive snapshots. The first qualifying transition loads register one and the second loads register two. Once both are loaded, the block ignores the pin until software restarts the slot sequence. A select input chooses whether the single-cycle capture event goes to the interrupt logic after the first snapshot or after the second.

The slot sequence restarts in two ways. One is a status-clear strobe. The other is a change of the edge mode from "off" to any active mode. A restart does not erase the stored values.

Top module: `dual_edge_capture`

## Requirements
- R1: `edge_mode_i` is encoded as 0 = off, 1 = rising (pin goes 0 to 1), 2 = falling (pin goes 1 to 0), 3 = either transition. In mode 0 no transition is captured.
- R2: A capture happens only while `dir_in_i` is 1. With `dir_in_i` at 0, transitions change neither capture register and raise no event.
- R3: The first qualifying transition after a restart loads `cap1_o` with the `count_i` value present at the capturing clock edge.
- R4: The second qualifying transition loads `cap2_o`. Later transitions are ignored until the next restart.
- R5: `cap_event_o` is a one-cycle pulse. It is raised with the first capture when `second_sel_i` is 0, and with the second capture when `second_sel_i` is 1.
- R6: A high `clr_cap_i` in a cycle restarts the slot sequence at register one. A transition qualifying in that same cycle is dropped.
- R7: A clock edge at which the edge mode moves from 0 to a nonzero value restarts the slot sequence, and a transition qualifying at that edge is dropped.
- R8: While `rst_n` is low, both capture registers are 0 and `cap_event_o` is 0.
- R9: A pin level driven before clock edge k is detected at edge k+2, so its capture and event appear on the outputs right after edge k+2.
- R10: A restart leaves both capture registers holding their previous values until new captures overwrite them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async_i | input | 1 | External capture pin, asynchronous |
| count_i | input | COUNT_W | Live timer count |
| dir_in_i | input | 1 | 1 = pin is used as an input (capture allowed) |
| edge_mode_i | input | 2 | Edge mode: 0 off, 1 rising, 2 falling, 3 both |
| second_sel_i | input | 1 | 0 = event on first capture, 1 = event on second |
| clr_cap_i | input | 1 | Status-clear strobe that restarts the slot sequence |
| cap1_o | output | COUNT_W | First capture register |
| cap2_o | output | COUNT_W | Second capture register |
| cap_event_o | output | 1 | One-cycle capture event |

## Verification
A pin change driven before clock edge k passes two synchronizer stages and one history flop. It is therefore judged at edge k+2, and the loaded register and the event pulse appear just after that edge. The control inputs (`count_i`, `edge_mode_i`, `clr_cap_i`, `dir_in_i`) take effect at the next edge they are sampled on, with no further delay.

The bench holds a behavioural model built on a queue of pin samples. It reads the entry two edges back to know what the hardware sees. It updates the model at each rising edge and compares all three outputs a quarter period later. Stimulus changes only on falling edges, so the result never depends on the order of processes at an edge.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_mode_e;

    typedef enum logic [1:0] {
        SLOT_FIRST  = 2'd0,
        SLOT_SECOND = 2'd1,
        SLOT_FULL   = 2'd2
    } slot_e;
endpackage

// File: rtl/cap_pin_sync.sv
module cap_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = pin_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], pin_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/cap_edge_qual.sv
module cap_edge_qual
    import cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    input  edge_mode_e mode_i,
    output logic       hit_o
);
    logic last_d, last_q;
    logic went_up, went_down;

    always_comb begin
        last_d    = level_i;
        went_up   = level_i & ~last_q;
        went_down = ~level_i & last_q;
        unique case (mode_i)
            EDGE_RISE: hit_o = went_up;
            EDGE_FALL: hit_o = went_down;
            EDGE_ANY:  hit_o = went_up | went_down;
            default:   hit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= last_d;
    end
endmodule

// File: rtl/cap_slot_bank.sv
module cap_slot_bank
    import cap_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_i,
    input  logic               dir_in_i,
    input  logic               second_sel_i,
    input  logic               restart_i,
    input  logic [COUNT_W-1:0] count_i,
    output logic [COUNT_W-1:0] cap1_o,
    output logic [COUNT_W-1:0] cap2_o,
    output logic               event_o
);
    typedef struct packed {
        slot_e              slot;
        logic [COUNT_W-1:0] first;
        logic [COUNT_W-1:0] second;
        logic               ev;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ev = 1'b0;
        if (restart_i) begin
            st_d.slot = SLOT_FIRST;
        end else if (hit_i && dir_in_i) begin
            unique case (st_q.slot)
                SLOT_FIRST: begin
                    st_d.first = count_i;
                    st_d.slot  = SLOT_SECOND;
                    st_d.ev    = ~second_sel_i;
                end
                SLOT_SECOND: begin
                    st_d.second = count_i;
                    st_d.slot   = SLOT_FULL;
                    st_d.ev     = second_sel_i;
                end
                default: st_d.slot = st_q.slot;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{slot: SLOT_FIRST, first: '0, second: '0, ev: 1'b0};
        else        st_q <= st_d;
    end

    assign cap1_o  = st_q.first;
    assign cap2_o  = st_q.second;
    assign event_o = st_q.ev;
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture
    import cap_pkg::*;
#(
    parameter int COUNT_W     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_async_i,
    input  logic [COUNT_W-1:0] count_i,
    input  logic               dir_in_i,
    input  logic [1:0]         edge_mode_i,
    input  logic               second_sel_i,
    input  logic               clr_cap_i,
    output logic [COUNT_W-1:0] cap1_o,
    output logic [COUNT_W-1:0] cap2_o,
    output logic               cap_event_o
);
    edge_mode_e mode_now, mode_d, mode_q;
    logic       pin_level;
    logic       hit;
    logic       restart;

    always_comb begin
        mode_now = edge_mode_e'(edge_mode_i);
        mode_d   = mode_now;
        restart  = clr_cap_i | ((mode_q == EDGE_OFF) && (mode_now != EDGE_OFF));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= EDGE_OFF;
        else        mode_q <= mode_d;
    end

    cap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_async_i),
        .level_o (pin_level)
    );

    cap_edge_qual u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pin_level),
        .mode_i  (mode_now),
        .hit_o   (hit)
    );

    cap_slot_bank #(.COUNT_W(COUNT_W)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_i        (hit),
        .dir_in_i     (dir_in_i),
        .second_sel_i (second_sel_i),
        .restart_i    (restart),
        .count_i      (count_i),
        .cap1_o       (cap1_o),
        .cap2_o       (cap2_o),
        .event_o      (cap_event_o)
    );
endmodule

// File: rtl/dual_edge_capture_chk.sv
module dual_edge_capture_chk #(
    parameter int COUNT_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dir_in_i,
    input logic [1:0]         edge_mode_i,
    input logic               clr_cap_i,
    input logic [COUNT_W-1:0] cap1_o,
    input logic [COUNT_W-1:0] cap2_o,
    input logic               cap_event_o
);
    assert_mode_off_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i == 2'd0) |=> ($stable(cap1_o) && $stable(cap2_o) && !cap_event_o));

    assert_output_dir_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_in_i |=> ($stable(cap1_o) && $stable(cap2_o) && !cap_event_o));

    assert_clear_drops_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cap_i |=> ($stable(cap1_o) && $stable(cap2_o) && !cap_event_o));

    assert_event_needs_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_event_o |-> ($past(dir_in_i) && ($past(edge_mode_i) != 2'd0)));

    always_comb begin
        if (!rst_n) begin
            assert_reset_clear_R8: assert ((cap1_o == '0) && (cap2_o == '0) && !cap_event_o);
        end
    end
endmodule

bind dual_edge_capture dual_edge_capture_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dir_in_i    (dir_in_i),
    .edge_mode_i (edge_mode_i),
    .clr_cap_i   (clr_cap_i),
    .cap1_o      (cap1_o),
    .cap2_o      (cap2_o),
    .cap_event_o (cap_event_o)
);

// File: tb/tb_dual_edge_capture.sv
`timescale 1ns/1ps
module tb_dual_edge_capture;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pin = 1'b0;
    logic [W-1:0] cnt = '0;
    logic         dir = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic         sel = 1'b0;
    logic         clr = 1'b0;
    logic [W-1:0] cap1, cap2;
    logic         ev;

    int    checks = 0;
    int    errors = 0;
    string tag = "R8";
    bit    done = 1'b0;

    always #10 clk = ~clk;

    dual_edge_capture #(.COUNT_W(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .pin_async_i(pin), .count_i(cnt),
        .dir_in_i(dir), .edge_mode_i(mode), .second_sel_i(sel),
        .clr_cap_i(clr), .cap1_o(cap1), .cap2_o(cap2), .cap_event_o(ev)
    );

    // Behavioural reference model
    bit          hist[$];
    int          m_slot = 0;
    logic [W-1:0] m_c1 = '0, m_c2 = '0;
    bit          m_ev = 0;
    int          m_prev_mode = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {1'b0, 1'b0, 1'b0};
            m_slot = 0; m_c1 = '0; m_c2 = '0; m_ev = 0; m_prev_mode = 0;
        end else begin
            bit now_l, old_l, qual, restart;
            hist.push_back(pin);
            now_l = hist[hist.size()-3];
            old_l = hist[hist.size()-4];
            case (mode)
                2'd1:    qual = now_l && !old_l;
                2'd2:    qual = !now_l && old_l;
                2'd3:    qual = now_l != old_l;
                default: qual = 0;
            endcase
            restart = clr || (m_prev_mode == 0 && mode != 2'd0);
            m_ev = 0;
            if (restart) m_slot = 0;
            else if (qual && dir) begin
                if (m_slot == 0) begin
                    m_c1 = cnt; m_slot = 1; m_ev = (sel == 1'b0);
                end else if (m_slot == 1) begin
                    m_c2 = cnt; m_slot = 2; m_ev = (sel == 1'b1);
                end
            end
            m_prev_mode = int'(mode);
            while (hist.size() > 8) void'(hist.pop_front());
        end
    end

    task automatic check(string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #5;
        if (!done) begin
            check("cap1", cap1, m_c1);
            check("cap2", cap2, m_c2);
            check("event", {{(W-1){1'b0}}, ev}, {{(W-1){1'b0}}, m_ev});
        end
    end

    always @(negedge clk) cnt <= cnt + 32'd7;

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(bit v, int hold);
        @(negedge clk); pin = v;
        idle(hold);
    endtask

    task automatic pulse_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    initial begin
        tag = "R8";
        pin = 1'b1;
        idle(4);
        check("reset cap1", cap1, '0);
        check("reset cap2", cap2, '0);
        pin = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        idle(3);

        tag = "R2";
        mode = 2'd1; dir = 1'b0;
        set_pin(1, 4); set_pin(0, 4); set_pin(1, 4); set_pin(0, 4);

        tag = "R3";
        @(negedge clk); dir = 1'b1; sel = 1'b0;
        set_pin(1, 5); set_pin(0, 5);
        tag = "R4";
        set_pin(1, 5); set_pin(0, 5);
        set_pin(1, 5); set_pin(0, 5);

        tag = "R6";
        pulse_clear();
        tag = "R10";
        idle(3);
        tag = "R5";
        @(negedge clk); mode = 2'd2; sel = 1'b1;
        set_pin(1, 5); set_pin(0, 5); set_pin(1, 5); set_pin(0, 5);
        set_pin(1, 5); set_pin(0, 5);

        tag = "R1";
        pulse_clear();
        @(negedge clk); mode = 2'd0;
        set_pin(1, 4); set_pin(0, 4);
        tag = "R7";
        set_pin(1, 1);
        @(negedge clk); mode = 2'd3;
        idle(4);
        set_pin(0, 4); set_pin(1, 4); set_pin(0, 4);

        tag = "R9";
        pulse_clear();
        @(negedge clk); sel = 1'b0;
        set_pin(1, 0);
        idle(1);
        check("no capture before edge k+2 R9", cap1 == m_c1 ? 32'd1 : 32'd0, 32'd1);
        idle(5);

        tag = "R6";
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            pin = ~pin;
            clr = (i % 3 == 1);
        end
        @(negedge clk); clr = 1'b0;

        tag = "R1";
        @(negedge clk); mode = 2'd1;
        pulse_clear();
        set_pin(0, 4); set_pin(1, 4);
        idle(5);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog run did not end");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule